// File: doc/BRIEF.md
# High/Low Threshold Hit Matcher

The block pairs hits that a group of detector channels reports through two discriminators, one with a high threshold and one with a low threshold. Each kind of hit waits in its own first-word-fall-through FIFO outside the block. The block reads both FIFOs through plain data/empty/pop interfaces. For every high-threshold hit that has a low-threshold partner close enough in time, it emits one primitive record. The record holds the block number, the absolute time and the rise time.

The high-threshold hit drives the search. While a high hit waits at the head of its FIFO, the block inspects the low FIFO. A low hit earlier than the match window is thrown away alone, and the search goes on. A low hit later than the high hit throws away both hits. A low hit inside the window produces a primitive, and both hits are popped. Within each FIFO, hits are assumed to be in time order. Times are treated as unsigned 40-bit values that do not wrap.

Back-pressure on the input side is only the pop strobes. A FIFO head is taken only in the cycle its pop is high. A head stays presented, unchanged, for as long as the block leaves it unpopped. The output has no ready: the primitive strobe is a single-cycle valid that the downstream logic must accept.

Top module: `hit_matcher`

## Requirements
- R1: During reset and in the cycles after reset, prim_valid, hi_pop and lo_pop are 0 until hits are presented.
- R2: While the high FIFO is empty, neither FIFO is popped, and a waiting low hit stays in its FIFO.
- R3: While a high hit is present and the low FIFO is empty, nothing is popped and no primitive is emitted.
- R4: Let the difference be high time minus low time. When it is between 0 and W inclusive, both FIFOs are popped in the same cycle. prim_valid is then 1 for exactly one cycle, the cycle after the pops.
- R5: A primitive carries prim_block = block_id, prim_time = the low-hit time and prim_rise = the difference saturated to 255 (8 bits).
- R6: When the difference exceeds W, only the low FIFO is popped and no primitive is emitted. The same high hit is then compared against the next low hit.
- R7: When the low time is later than the high time, both FIFOs are popped and no primitive is emitted.
- R8: W is captured from match_win into a register on every clock. A decision uses the value that was on match_win one cycle earlier.
- R9: A FIFO is never popped while it is empty, and the high FIFO is popped only together with the low FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_win | input | 16 | Match window W, in time units |
| block_id | input | 6 | Block number copied into each primitive |
| hi_time | input | 40 | Head of high-threshold FIFO |
| hi_empty | input | 1 | High-threshold FIFO empty |
| hi_pop | output | 1 | Pop high-threshold FIFO |
| lo_time | input | 40 | Head of low-threshold FIFO |
| lo_empty | input | 1 | Low-threshold FIFO empty |
| lo_pop | output | 1 | Pop low-threshold FIFO |
| prim_valid | output | 1 | One-cycle primitive strobe |
| prim_block | output | 6 | Primitive block number |
| prim_time | output | 40 | Primitive absolute time |
| prim_rise | output | 8 | Primitive rise time |

## Verification
A wrong verdict from the comparator shows up within two clocks of both heads being present. It appears as a missing or extra prim_valid, or as the wrong set of pop strobes. The bench tracks the pops by watching how far its own FIFO models advance. A controller stuck in its waiting state shows up as hits never being consumed. A lost head, caused by a pop in the wrong cycle, shows up as a following primitive with the wrong time or rise. The window register is exercised at both edges of W, so an off-by-one is seen on the first boundary pair.

// File: rtl/hm_pkg.sv
package hm_pkg;
  typedef enum logic [1:0] {
    V_MATCH = 2'd0,
    V_EARLY = 2'd1,
    V_LATE  = 2'd2
  } verdict_e;

  typedef enum logic {
    S_WAIT_HI = 1'b0,
    S_SEEK    = 1'b1
  } state_e;
endpackage

// File: rtl/hm_classify.sv
module hm_classify
  import hm_pkg::*;
#(
  parameter int TIME_W = 40,
  parameter int WIN_W  = 16,
  parameter int RISE_W = 8
) (
  input  logic [TIME_W-1:0] hi_t,
  input  logic [TIME_W-1:0] lo_t,
  input  logic [WIN_W-1:0]  win,
  output verdict_e          verdict,
  output logic [RISE_W-1:0] rise
);
  localparam int DW = TIME_W + 1;

  logic [DW-1:0]     diff;
  logic [TIME_W-1:0] mag;
  logic              late;
  logic              early;
  logic              over;

  always_comb begin
    diff  = {1'b0, hi_t} - {1'b0, lo_t};
    late  = diff[DW-1];
    mag   = diff[TIME_W-1:0];
    early = !late && (mag > TIME_W'(win));
    over  = |mag[TIME_W-1:RISE_W];
    rise  = over ? {RISE_W{1'b1}} : mag[RISE_W-1:0];
    if (late)       verdict = V_LATE;
    else if (early) verdict = V_EARLY;
    else            verdict = V_MATCH;
  end
endmodule

// File: rtl/hm_ctrl.sv
module hm_ctrl
  import hm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hi_empty,
  input  logic     lo_empty,
  input  verdict_e verdict,
  output logic     hi_pop,
  output logic     lo_pop,
  output logic     emit
);
  state_e state, state_nx;

  always_comb begin
    state_nx = state;
    hi_pop   = 1'b0;
    lo_pop   = 1'b0;
    emit     = 1'b0;
    unique case (state)
      S_WAIT_HI: if (!hi_empty) state_nx = S_SEEK;
      S_SEEK: begin
        if (hi_empty) begin
          state_nx = S_WAIT_HI;
        end else if (!lo_empty) begin
          unique case (verdict)
            V_MATCH: begin
              hi_pop   = 1'b1;
              lo_pop   = 1'b1;
              emit     = 1'b1;
              state_nx = S_WAIT_HI;
            end
            V_LATE: begin
              hi_pop   = 1'b1;
              lo_pop   = 1'b1;
              state_nx = S_WAIT_HI;
            end
            default: lo_pop = 1'b1;
          endcase
        end
      end
      default: state_nx = S_WAIT_HI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_WAIT_HI;
    else     state <= state_nx;
  end
endmodule

// File: rtl/hm_format.sv
module hm_format #(
  parameter int TIME_W = 40,
  parameter int BLK_W  = 6,
  parameter int RISE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  logic [BLK_W-1:0]  blk_in,
  input  logic [TIME_W-1:0] time_in,
  input  logic [RISE_W-1:0] rise_in,
  output logic              valid,
  output logic [BLK_W-1:0]  blk,
  output logic [TIME_W-1:0] tim,
  output logic [RISE_W-1:0] rise
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      blk   <= '0;
      tim   <= '0;
      rise  <= '0;
    end else begin
      valid <= emit;
      if (emit) begin
        blk  <= blk_in;
        tim  <= time_in;
        rise <= rise_in;
      end
    end
  end
endmodule

// File: rtl/hit_matcher.sv
module hit_matcher
  import hm_pkg::*;
#(
  parameter int TIME_W = 40,
  parameter int WIN_W  = 16,
  parameter int BLK_W  = 6,
  parameter int RISE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIN_W-1:0]  match_win,
  input  logic [BLK_W-1:0]  block_id,
  input  logic [TIME_W-1:0] hi_time,
  input  logic              hi_empty,
  output logic              hi_pop,
  input  logic [TIME_W-1:0] lo_time,
  input  logic              lo_empty,
  output logic              lo_pop,
  output logic              prim_valid,
  output logic [BLK_W-1:0]  prim_block,
  output logic [TIME_W-1:0] prim_time,
  output logic [RISE_W-1:0] prim_rise
);
  logic [WIN_W-1:0]  win_q;
  verdict_e          verdict;
  logic [RISE_W-1:0] rise_c;
  logic              emit;

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else     win_q <= match_win;
  end

  hm_classify #(.TIME_W(TIME_W), .WIN_W(WIN_W), .RISE_W(RISE_W)) u_cls (
    .hi_t(hi_time), .lo_t(lo_time), .win(win_q),
    .verdict(verdict), .rise(rise_c)
  );

  hm_ctrl u_ctrl (
    .clk(clk), .rst(rst), .hi_empty(hi_empty), .lo_empty(lo_empty),
    .verdict(verdict), .hi_pop(hi_pop), .lo_pop(lo_pop), .emit(emit)
  );

  hm_format #(.TIME_W(TIME_W), .BLK_W(BLK_W), .RISE_W(RISE_W)) u_fmt (
    .clk(clk), .rst(rst), .emit(emit),
    .blk_in(block_id), .time_in(lo_time), .rise_in(rise_c),
    .valid(prim_valid), .blk(prim_block), .tim(prim_time), .rise(prim_rise)
  );
endmodule

// File: rtl/hm_checker.sv
module hm_checker #(
  parameter int TIME_W = 40,
  parameter int RISE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              hi_empty,
  input logic              lo_empty,
  input logic              hi_pop,
  input logic              lo_pop,
  input logic [TIME_W-1:0] lo_time,
  input logic              prim_valid,
  input logic [TIME_W-1:0] prim_time
);
  a_r9_no_pop_empty_hi: assert property (@(posedge clk) disable iff (rst) hi_pop |-> !hi_empty);
  a_r9_no_pop_empty_lo: assert property (@(posedge clk) disable iff (rst) lo_pop |-> !lo_empty);
  a_r9_hi_with_lo:      assert property (@(posedge clk) disable iff (rst) hi_pop |-> lo_pop);
  a_r2_hold_low:        assert property (@(posedge clk) disable iff (rst) hi_empty |-> !lo_pop);
  a_r6_lone_low_quiet:  assert property (@(posedge clk) disable iff (rst) (lo_pop && !hi_pop) |=> !prim_valid);
  a_r4_single_pulse:    assert property (@(posedge clk) disable iff (rst) prim_valid |=> !prim_valid);
  a_r4_valid_after_pop: assert property (@(posedge clk) disable iff (rst)
                                         (!$past(rst) && prim_valid) |-> $past(hi_pop && lo_pop));
  a_r5_time_is_low:     assert property (@(posedge clk) disable iff (rst)
                                         (!$past(rst) && prim_valid) |-> prim_time == $past(lo_time));
endmodule

bind hit_matcher hm_checker #(.TIME_W(TIME_W), .RISE_W(RISE_W)) u_hm_checker (
  .clk(clk), .rst(rst), .hi_empty(hi_empty), .lo_empty(lo_empty),
  .hi_pop(hi_pop), .lo_pop(lo_pop), .lo_time(lo_time),
  .prim_valid(prim_valid), .prim_time(prim_time)
);

// File: tb/test_hit_matcher.sv
module test_hit_matcher;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] match_win = 16'd10;
  logic [5:0]  block_id = 6'h2A;
  logic [39:0] hi_time, lo_time;
  logic        hi_empty, lo_empty, hi_pop, lo_pop;
  logic        prim_valid;
  logic [5:0]  prim_block;
  logic [39:0] prim_time;
  logic [7:0]  prim_rise;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [39:0] hi_mem [0:63];
  logic [39:0] lo_mem [0:63];
  int hi_wr = 0, hi_rp = 0, lo_wr = 0, lo_rp = 0;

  logic [39:0] got_time [0:63];
  logic [7:0]  got_rise [0:63];
  logic [5:0]  got_blk  [0:63];
  int got_n = 0;

  always #5 clk = ~clk;

  assign hi_empty = (hi_rp == hi_wr);
  assign lo_empty = (lo_rp == lo_wr);
  assign hi_time  = hi_mem[hi_rp % 64];
  assign lo_time  = lo_mem[lo_rp % 64];

  hit_matcher i_hit_matcher (
    .clk(clk), .rst(rst), .match_win(match_win), .block_id(block_id),
    .hi_time(hi_time), .hi_empty(hi_empty), .hi_pop(hi_pop),
    .lo_time(lo_time), .lo_empty(lo_empty), .lo_pop(lo_pop),
    .prim_valid(prim_valid), .prim_block(prim_block),
    .prim_time(prim_time), .prim_rise(prim_rise)
  );

  always @(posedge clk) begin
    if (hi_pop) begin
      if (hi_empty) begin
        miscompares++;
        $display("FAIL R9 pop of empty high FIFO: got 1 expected 0");
      end
      hi_rp <= hi_rp + 1;
    end
    if (lo_pop) begin
      if (lo_empty) begin
        miscompares++;
        $display("FAIL R9 pop of empty low FIFO: got 1 expected 0");
      end
      lo_rp <= lo_rp + 1;
    end
  end

  always @(negedge clk) begin
    if (prim_valid && got_n < 64) begin
      got_time[got_n] = prim_time;
      got_rise[got_n] = prim_rise;
      got_blk[got_n]  = prim_block;
      got_n++;
    end
  end

  task automatic check(string req, string what, longint got, longint exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic push_hi(logic [39:0] t);
    hi_mem[hi_wr % 64] = t;
    hi_wr++;
  endtask

  task automatic push_lo(logic [39:0] t);
    lo_mem[lo_wr % 64] = t;
    lo_wr++;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] sat_rise(logic [39:0] h, logic [39:0] l);
    return (h - l > 40'd255) ? 8'hFF : 8'(h - l);
  endfunction

  task automatic set_win(logic [15:0] w);
    @(negedge clk);
    match_win = w;
    idle(2);
  endtask

  task automatic check_prim(string req, int idx, logic [39:0] h, logic [39:0] l);
    check(req, "prim_time", got_time[idx], l);
    check(req, "prim_rise", got_rise[idx], sat_rise(h, l));
    check(req, "prim_block", got_blk[idx], block_id);
  endtask

  task automatic t_reset;
    idle(3);
    check("R1", "prim_valid in reset", prim_valid, 0);
    check("R1", "hi_pop in reset", hi_pop, 0);
    @(negedge clk);
    rst = 1'b0;
    idle(3);
    check("R1", "prim_valid after reset", prim_valid, 0);
    check("R1", "lo_pop after reset", lo_pop, 0);
  endtask

  task automatic t_simple_match;
    int n0 = got_n;
    set_win(16'd10);
    push_hi(40'd1000); push_lo(40'd995);
    idle(8);
    check("R4", "primitive count", got_n - n0, 1);
    check("R4", "high consumed", hi_rp, hi_wr);
    check("R4", "low consumed", lo_rp, lo_wr);
    check_prim("R5", n0, 40'd1000, 40'd995);
  endtask

  task automatic t_early_low;
    int n0 = got_n;
    push_lo(40'd1900); push_lo(40'd1998); push_hi(40'd2000);
    idle(10);
    check("R6", "primitive count", got_n - n0, 1);
    check("R6", "both lows consumed", lo_rp, lo_wr);
    check("R6", "high consumed", hi_rp, hi_wr);
    check_prim("R6", n0, 40'd2000, 40'd1998);
  endtask

  task automatic t_late_low;
    int n0 = got_n;
    int h0 = hi_rp;
    int l0 = lo_rp;
    push_hi(40'd3000); push_lo(40'd3005);
    idle(8);
    check("R7", "no primitive", got_n - n0, 0);
    check("R7", "high popped", hi_rp - h0, 1);
    check("R7", "low popped", lo_rp - l0, 1);
    push_hi(40'd4000); push_lo(40'd3991);
    idle(8);
    check("R7", "next pair matched", got_n - n0, 1);
    check_prim("R7", n0, 40'd4000, 40'd3991);
  endtask

  task automatic t_boundaries;
    int n0 = got_n;
    push_hi(40'd5000); push_lo(40'd4990);
    idle(8);
    check("R4", "diff equals W matches", got_n - n0, 1);
    check_prim("R4", n0, 40'd5000, 40'd4990);
    push_hi(40'd6000); push_lo(40'd6000);
    idle(8);
    check("R5", "equal times give rise 0", got_n - n0, 2);
    check_prim("R5", n0 + 1, 40'd6000, 40'd6000);
    push_hi(40'd7000); push_lo(40'd6989);
    idle(8);
    check("R6", "diff W+1 not matched", got_n - n0, 2);
    check("R6", "high kept", hi_rp, hi_wr - 1);
    push_lo(40'd6999);
    idle(8);
    check("R6", "same high matched later", got_n - n0, 3);
    check_prim("R6", n0 + 2, 40'd7000, 40'd6999);
  endtask

  task automatic t_saturate_and_window;
    int n0 = got_n;
    set_win(16'd1000);
    push_hi(40'd9000); push_lo(40'd8500);
    idle(8);
    check("R8", "wider window matches", got_n - n0, 1);
    check("R5", "saturated rise", got_rise[n0], 255);
    check("R5", "time of saturated", got_time[n0], 8500);
    set_win(16'd3);
    push_hi(40'd9100); push_lo(40'd9095); push_lo(40'd9098);
    idle(10);
    check("R8", "narrow window one match", got_n - n0, 2);
    check_prim("R8", n0 + 1, 40'd9100, 40'd9098);
  endtask

  task automatic t_waiting;
    int n0 = got_n;
    int l0 = lo_rp;
    int h0 = hi_rp;
    set_win(16'd10);
    push_lo(40'd10000);
    idle(20);
    check("R2", "low kept without high", lo_rp - l0, 0);
    check("R2", "no primitive", got_n - n0, 0);
    push_hi(40'd10004);
    idle(8);
    check("R2", "pair then matched", got_n - n0, 1);
    push_hi(40'd11000);
    idle(20);
    check("R3", "high kept without low", hi_rp - h0, 1);
    check("R3", "no primitive", got_n - n0, 1);
    push_lo(40'd10999);
    idle(8);
    check("R3", "match after low arrives", got_n - n0, 2);
    check_prim("R3", n0 + 1, 40'd11000, 40'd10999);
  endtask

  task automatic t_stream;
    int n0 = got_n;
    for (int i = 0; i < 6; i++) begin
      push_hi(40'd20000 + 40'(i * 100));
      push_lo(40'd20000 + 40'(i * 100) - 40'(i));
    end
    idle(30);
    check("R4", "stream primitive count", got_n - n0, 6);
    for (int i = 0; i < 6; i++)
      check_prim("R5", n0 + i, 40'd20000 + 40'(i * 100), 40'd20000 + 40'(i * 100) - 40'(i));
  endtask

  initial begin
    t_reset();
    t_simple_match();
    t_early_low();
    t_late_low();
    t_boundaries();
    t_saturate_and_window();
    t_waiting();
    t_stream();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule